// File: doc/BRIEF.md
# Clock-Crossing Word Queue with Toggle Hand-off

This block buffers words written in a producer clock domain and delivers them, one at a time, to a consumer running on an unrelated clock. The storage array, both address pointers and the occupancy counter all live in the producer domain, so they are ordinary binary counters. Only two single-bit control lines cross between the domains. A request toggle goes toward the consumer, and an acknowledge toggle comes back. Each line passes through a chain of flip-flops clocked by the receiving side.

When the hand-off path is idle and the store holds a word, the producer side moves the oldest word into a hand-off register and flips the request toggle. The hand-off register drives `rdata` directly. The consumer sees `ravail` once the synchronized request differs from its own acknowledge toggle. Pulsing `rtake` flips the acknowledge toggle. When that flip reaches the producer, the next word may be launched. The hand-off register is frozen for the whole round trip, so the consumer never sees it change.

The block suits links that move a word only now and then, not on every clock. `wfull` rises a programmable number of entries before the store is truly full. A producer that reacts late to the flag therefore loses nothing.

Top module: `fhx_link`

## Requirements
- R1: While either reset is asserted and right after both are released, `wfull` is low and `ravail` is low.
- R2: Words reach `rdata` in the order they were accepted, with their values unchanged.
- R3: Each accepted word is presented exactly once. In the `rclk` cycle after `rtake` is sampled high with `ravail` high, `ravail` is low. A word that has been taken never reappears.
- R4: While `ravail` is high and `rtake` is low, `rdata` holds its value and `ravail` stays high.
- R5: Occupancy counts the words in the store, not counting the word in the hand-off register. `wfull` is registered and, after each `wclk` edge, equals (occupancy >= DEPTH − MARGIN). With DEPTH = 8 and MARGIN = 2 it is high from 6 entries.
- R6: A write is accepted on a `wclk` edge when `wvalid` is high and occupancy is below DEPTH, even if `wfull` is high. Otherwise the write is dropped. With the consumer stalled, the block holds DEPTH + 1 words.
- R7: On an edge that both accepts a write and launches a word into the hand-off register, occupancy is unchanged.
- R8: A word written into an empty, idle block raises `ravail` within 60 `rclk` cycles.
- R9: `rtake` while `ravail` is low has no effect. The next word written is still delivered once and intact.
- R10: Asserting both resets while words are queued or in flight discards them all. Only words written after reset are delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-domain asynchronous reset, active low |
| wdata | input | WIDTH | Word to enqueue |
| wvalid | input | 1 | Write request |
| wfull | output | 1 | Early full indication |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-domain asynchronous reset, active low |
| rdata | output | WIDTH | Word currently offered to the consumer |
| ravail | output | 1 | A word is offered on `rdata` |
| rtake | input | 1 | Consumer accepts the offered word |

## Verification
On every clock, the assertions check the following:
- Occupancy never exceeds the store depth.
- A write that coincides with a launch leaves occupancy unchanged.
- The hand-off register is frozen while a transfer is outstanding.
- `ravail` drops right after a take.
- `rdata` is steady while a word is offered.

Only the bench scenarios can show the end-to-end behaviour:
- Ordering and values across the clock crossing.
- The exact edge at which `wfull` rises.
- The DEPTH + 1 capacity and the dropping of excess writes.
- That a stray take or a reset leaves no stale or duplicated word.

// File: rtl/fhx_pkg.sv
package fhx_pkg;
    localparam int FHX_WIDTH  = 8;
    localparam int FHX_DEPTH  = 8;
    localparam int FHX_MARGIN = 2;
    localparam int FHX_SYNC   = 2;
endpackage

// File: rtl/fhx_sync.sv
module fhx_sync #(
    parameter int STAGES = fhx_pkg::FHX_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end else begin : g_single
            always_comb sh_d = d;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/fhx_store.sv
module fhx_store #(
    parameter int WIDTH  = fhx_pkg::FHX_WIDTH,
    parameter int DEPTH  = fhx_pkg::FHX_DEPTH,
    parameter int MARGIN = fhx_pkg::FHX_MARGIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             ack_s,
    output logic             full,
    output logic             req_tgl,
    output logic [WIDTH-1:0] hold_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP    = CW'(DEPTH);
    localparam logic [CW-1:0] THRESH = CW'(DEPTH - MARGIN);

    typedef struct packed {
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [CW-1:0]    cnt;
        logic             full;
        logic             req;
        logic [WIDTH-1:0] hold;
    } st_t;

    st_t cur_q, nxt_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic wr_en, busy, launch;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        nxt_d  = cur_q;
        wr_en  = wr_valid && (cur_q.cnt < CAP);
        busy   = (cur_q.req != ack_s);
        launch = !busy && (cur_q.cnt != '0);
        if (wr_en) nxt_d.wptr = bump(cur_q.wptr);
        if (launch) begin
            nxt_d.rptr = bump(cur_q.rptr);
            nxt_d.hold = mem_q[cur_q.rptr];
            nxt_d.req  = ~cur_q.req;
        end
        case ({wr_en, launch})
            2'b10:   nxt_d.cnt = cur_q.cnt + 1'b1;
            2'b01:   nxt_d.cnt = cur_q.cnt - 1'b1;
            default: nxt_d.cnt = cur_q.cnt;
        endcase
        nxt_d.full = (nxt_d.cnt >= THRESH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[cur_q.wptr] <= wr_data;
    end

    assign full      = cur_q.full;
    assign req_tgl   = cur_q.req;
    assign hold_data = cur_q.hold;

    // R6
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CAP);
    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && launch) |=> $stable(cur_q.cnt));
    // R4
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_q.hold));
endmodule

// File: rtl/fhx_cons.sv
module fhx_cons (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic take,
    output logic avail,
    output logic ack_tgl
);
    typedef struct packed {
        logic ack;
    } cst_t;

    cst_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        avail = (req_s != cur_q.ack);
        if (avail && take) nxt_d.ack = ~cur_q.ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ack_tgl = cur_q.ack;

    // R3
    take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && take) |=> !avail);
endmodule

// File: rtl/fhx_link.sv
module fhx_link #(
    parameter int WIDTH  = fhx_pkg::FHX_WIDTH,
    parameter int DEPTH  = fhx_pkg::FHX_DEPTH,
    parameter int MARGIN = fhx_pkg::FHX_MARGIN,
    parameter int SYNC   = fhx_pkg::FHX_SYNC
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic [WIDTH-1:0] wdata,
    input  logic             wvalid,
    output logic             wfull,
    input  logic             rclk,
    input  logic             rrst_n,
    output logic [WIDTH-1:0] rdata,
    output logic             ravail,
    input  logic             rtake
);
    logic req_w, req_r, ack_r, ack_w;

    fhx_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_store (
        .clk(wclk), .rst_n(wrst_n), .wr_data(wdata), .wr_valid(wvalid),
        .ack_s(ack_w), .full(wfull), .req_tgl(req_w), .hold_data(rdata)
    );

    fhx_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(rclk), .rst_n(rrst_n), .d(req_w), .q(req_r)
    );

    fhx_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(wclk), .rst_n(wrst_n), .d(ack_r), .q(ack_w)
    );

    fhx_cons u_cons (
        .clk(rclk), .rst_n(rrst_n), .req_s(req_r), .take(rtake),
        .avail(ravail), .ack_tgl(ack_r)
    );

    // R4
    rdata_steady_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
        (ravail && !rtake) |=> (ravail && $stable(rdata)));
endmodule

// File: tb/fhx_link_test.sv
module fhx_link_test;
    localparam int W = 8, D = 8, M = 2;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic [W-1:0] wdata = '0, rdata;
    logic wvalid = 0, wfull, ravail, rtake = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 wclk = ~wclk;
    always #13 rclk = ~rclk;

    fhx_link #(.WIDTH(W), .DEPTH(D), .MARGIN(M), .SYNC(2)) uut (
        .wclk(wclk), .wrst_n(wrst_n), .wdata(wdata), .wvalid(wvalid), .wfull(wfull),
        .rclk(rclk), .rrst_n(rrst_n), .rdata(rdata), .ravail(ravail), .rtake(rtake)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic take_word(output logic [W-1:0] v, output bit got);
        got = 0; v = '0;
        for (int t = 0; t < 60 && !got; t++) begin
            @(negedge rclk);
            if (ravail) got = 1;
        end
        if (got) begin
            v = rdata;
            rtake = 1;
            @(negedge rclk);
            rtake = 0;
            chk(!ravail, "R3 avail drop after take", ravail, 0);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge wclk);
        repeat (n) @(negedge rclk);
    endtask

    task automatic quiet_check(input string req);
        bit seen = 0;
        for (int t = 0; t < 20; t++) begin
            @(negedge rclk);
            if (ravail) seen = 1;
        end
        chk(!seen, req, seen, 0);
    endtask

    initial begin
        repeat (400000) @(posedge wclk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        bit got;
        // R1 reset state
        #1;
        chk(!wfull && !ravail, "R1 during reset", {wfull, ravail}, 0);
        repeat (3) @(negedge wclk);
        wrst_n = 1; rrst_n = 1;
        idle(3);
        chk(!wfull && !ravail, "R1 after reset", {wfull, ravail}, 0);

        // Sweep burst length, consumer stalled: R5 R6 R7 R2 R3
        for (int n = 1; n <= D + 3; n++) begin
            int acc;
            acc = (n < D + 1) ? n : D + 1;
            @(negedge wclk);
            for (int k = 1; k <= n; k++) begin
                int occ, expf;
                wdata = W'(n * 16 + k - 1);
                wvalid = 1;
                @(posedge wclk);
                @(negedge wclk);
                occ  = (k == 1) ? 1 : ((k - 1 < D) ? k - 1 : D);
                expf = (occ >= D - M) ? 1 : 0;
                chk(wfull == expf, "R5 R7 full edge", wfull, expf);
            end
            wvalid = 0;
            for (int j = 0; j < acc; j++) begin
                take_word(v, got);
                chk(got && v == W'(n * 16 + j), "R2 R6 R8 burst word", v, W'(n * 16 + j));
            end
            quiet_check("R3 R6 no extra word");
            idle(6);
            chk(!wfull, "R5 full clears when empty", wfull, 0);
        end

        // Concurrent streaming with gaps: R2
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge wclk);
                    while (wfull) @(negedge wclk);
                    if (i % 3 == 0) @(negedge wclk);
                    wdata = W'(8'h80 + i);
                    wvalid = 1;
                    @(posedge wclk);
                    @(negedge wclk);
                    wvalid = 0;
                end
            end
            begin
                for (int i = 0; i < 40; i++) begin
                    logic [W-1:0] s;
                    bit g;
                    take_word(s, g);
                    chk(g && s == W'(8'h80 + i), "R2 stream order", s, W'(8'h80 + i));
                    repeat (i % 4) @(negedge rclk);
                end
            end
        join
        quiet_check("R3 stream no extra");

        // Spurious take while empty: R9
        idle(4);
        @(negedge rclk);
        rtake = 1;
        repeat (3) @(negedge rclk);
        rtake = 0;
        chk(!ravail, "R9 idle take", ravail, 0);
        @(negedge wclk);
        wdata = 8'hA5; wvalid = 1;
        @(negedge wclk);
        wvalid = 0;
        take_word(v, got);
        chk(got && v == 8'hA5, "R9 R8 word after stray take", v, 8'hA5);
        quiet_check("R9 no duplicate");

        // Reset mid-flight: R10
        idle(4);
        @(negedge wclk);
        for (int k = 0; k < 7; k++) begin
            wdata = W'(8'h40 + k); wvalid = 1;
            @(negedge wclk);
        end
        wvalid = 0;
        idle(4);
        wrst_n = 0; rrst_n = 0;
        #1;
        chk(!wfull && !ravail, "R10 R1 flags in reset", {wfull, ravail}, 0);
        repeat (3) @(negedge wclk);
        wrst_n = 1; rrst_n = 1;
        idle(3);
        chk(!wfull && !ravail, "R10 R1 flags after reset", {wfull, ravail}, 0);
        @(negedge wclk);
        wdata = 8'h11; wvalid = 1;
        @(negedge wclk);
        wdata = 8'h22;
        @(negedge wclk);
        wvalid = 0;
        take_word(v, got);
        chk(got && v == 8'h11, "R10 first new word", v, 8'h11);
        take_word(v, got);
        chk(got && v == 8'h22, "R10 second new word", v, 8'h22);
        quiet_check("R10 no stale word");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule